// File: doc/BRIEF.md
# Wake Event Aggregation Controller

This block gathers wake events from eight general-purpose inputs and interrupt requests from eight peripheral sources. It presents them to software through a small register file on a byte-wide read/write bus. Rising edges on the general-purpose inputs are latched as wake status. A latched bit raises the active-low wake request output only when that source's enable bit and the global enable bit are also set. The device interrupt levels, each gated by its own enable bit, drive a separate wake status bus. A live interrupt status register shows the current level of a subset of the device sources.

Two reset domains are modelled. The standby reset clears everything. The main reset stands for a main-power, soft or bus reset. It clears the global enable, the interrupt status view and the output registers, but it leaves both enable registers and the latched wake status unchanged. Every asynchronous input passes through a two-flop synchronizer before it is used.

Top module: `wake_agg_ctrl`

## Requirements
- R1: After standby reset (`sb_rst_n` low), both enable registers (address 0 for the general-purpose inputs, address 1 for the devices), the control register (address 4), the wake status register (address 3) and `wake_bus` are all 0. `wake_req_n` is 1 and the interrupt status register (address 2) reads 0x02. Unused addresses read 0.
- R2: `wake_req_n` is 0 exactly when the control register bit 0 (global enable) is 1 and some bit k has both wake-enable bit k and wake status bit k set. It is registered one cycle after that state, and it stays 1 whenever the global enable is 0.
- R3: Wake status bit k is set by a rising edge on `gpio_wake_in[k]` after two synchronizer flops, whatever the state of the enable bit. It is readable 3 clock edges after the input changes. A source whose enable bit is 0 still records status but does not pull `wake_req_n` low.
- R4: A write to address 3 clears each status bit written with 1 and leaves the bits written with 0 unchanged. If a new edge arrives in the same cycle as the clearing write, the bit stays set.
- R5: Both enable registers and the wake status register keep their contents through a main reset (`main_rst_n` low). Bus writes are ignored while the main reset is active. These registers return to 0 only on standby reset.
- R6: `wake_bus[k]` is registered as device-enable bit k AND device source k. Source 0 is the parallel port interrupt, and source k (k = 1 to 7) is `dev_irq_in[k-1]`, in the order second serial, first serial, floppy, mouse, keyboard, watchdog, SMBus. The bit never asserts while its enable bit is 0.
- R7: The interrupt status register (address 2) shows live synchronized levels. Bit 1 is the parallel port interrupt, bit 2 is the second serial port, bit 3 is the first serial port, bit 4 is the floppy and bit 7 is the watchdog. Bits 0, 5 and 6 read 0. The register resets to 0x02 on either reset.
- R8: The parallel port interrupt is 1 while `par_active` is 0 and follows `par_ack_in` while `par_active` is 1.
- R9: Writes to address 2 have no effect. An interrupt status bit clears only when its source deasserts.
- R10: A main reset clears the global enable and returns the interrupt status register to 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sb_rst_n | input | 1 | Standby-power reset, active low, asynchronous |
| main_rst_n | input | 1 | Main-power/soft/bus reset, active low, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gpio_wake_in | input | 8 | Asynchronous general-purpose wake inputs |
| dev_irq_in | input | 7 | Asynchronous device interrupt levels for sources 1 to 7 |
| par_active | input | 1 | Parallel port activated |
| par_ack_in | input | 1 | Parallel port acknowledge level |
| wake_req_n | output | 1 | Wake request, active low |
| wake_bus | output | 8 | Enabled device wake status bus |

## Verification
On every cycle, the assertions check the following: the wake request never asserts unless the global enable was set, the wake status bus never carries a source whose enable bit was clear, edges are latched, enables stay stable during a main reset, and the parallel port interrupt reads 1 while the port is inactive. Only the bench scenarios can show the full register map, the synchronizer latency and the selective write-1-to-clear behaviour. They also cover which registers survive each reset type, that writes to the interrupt status address are ignored, and that the wake request follows the enable, status and global-enable combination across random input patterns.

// File: rtl/wake_agg_pkg.sv
package wake_agg_pkg;
   localparam int unsigned ADDR_GPIO_EN  = 0;
   localparam int unsigned ADDR_DEV_EN   = 1;
   localparam int unsigned ADDR_INT_STS  = 2;
   localparam int unsigned ADDR_GPIO_STS = 3;
   localparam int unsigned ADDR_CTRL     = 4;

   localparam int unsigned CTRL_GEN_BIT  = 0;

   localparam int unsigned INT_PAR_BIT   = 1;
   localparam int unsigned INT_SER2_BIT  = 2;
   localparam int unsigned INT_SER1_BIT  = 3;
   localparam int unsigned INT_FDC_BIT   = 4;
   localparam int unsigned INT_WDG_BIT   = 7;

   localparam int unsigned SRC_SER2      = 1;
   localparam int unsigned SRC_SER1      = 2;
   localparam int unsigned SRC_FDC       = 3;
   localparam int unsigned SRC_WDG       = 6;

   localparam logic [7:0]  INT_STS_RESET = 8'h02;
endpackage

// File: rtl/wake_sync_bank.sv
module wake_sync_bank #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wake_sync_bank: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wake_sync_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_async;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/wake_edge_latch.sv
module wake_edge_latch #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] clr,
   output logic [N-1:0] sts
);
   logic [N-1:0] prev_q;
   logic [N-1:0] sts_q;
   logic [N-1:0] rise;

   assign rise = lvl & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         sts_q  <= '0;
      end else begin
         prev_q <= lvl;
         sts_q  <= (sts_q & ~clr) | rise;
      end
   end

   assign sts = sts_q;

   // R3
   set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((sts & $past(rise)) == $past(rise)));

   // R4
   clear_only_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr == '0) |=> ((sts & $past(sts)) == $past(sts)));
endmodule

// File: rtl/wake_irq_view.sv
module wake_irq_view
   import wake_agg_pkg::*;
#(
   parameter int unsigned N_DEV  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DEV-2:0]  dev_s,
   input  logic              par_act_s,
   input  logic              par_ack_s,
   output logic [N_DEV-1:0]  dev_vec,
   output logic [DATA_W-1:0] int_sts
);
   if (N_DEV != 8) begin : g_bad_ndev
      $error("wake_irq_view: device layout needs N_DEV == 8");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("wake_irq_view: status layout needs DATA_W == 8");
   end

   logic              par_int;
   logic [DATA_W-1:0] int_nxt;
   logic [DATA_W-1:0] int_q;

   assign par_int = par_act_s ? par_ack_s : 1'b1;
   assign dev_vec = {dev_s, par_int};

   always_comb begin
      int_nxt               = '0;
      int_nxt[INT_PAR_BIT]  = par_int;
      int_nxt[INT_SER2_BIT] = dev_vec[SRC_SER2];
      int_nxt[INT_SER1_BIT] = dev_vec[SRC_SER1];
      int_nxt[INT_FDC_BIT]  = dev_vec[SRC_FDC];
      int_nxt[INT_WDG_BIT]  = dev_vec[SRC_WDG];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_q <= DATA_W'(INT_STS_RESET);
      else        int_q <= int_nxt;
   end

   assign int_sts = int_q;

   // R8
   par_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !par_act_s |=> int_sts[INT_PAR_BIT]);

   // R7
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_sts[0] == 1'b0) && (int_sts[6:5] == 2'b00));
endmodule

// File: rtl/wake_agg_ctrl.sv
module wake_agg_ctrl
   import wake_agg_pkg::*;
#(
   parameter int unsigned N_GPIO      = 8,
   parameter int unsigned N_DEV       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              sb_rst_n,
   input  logic              main_rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_GPIO-1:0] gpio_wake_in,
   input  logic [N_DEV-2:0]  dev_irq_in,
   input  logic              par_active,
   input  logic              par_ack_in,
   output logic              wake_req_n,
   output logic [N_DEV-1:0]  wake_bus
);
   localparam int unsigned DEV_SYNC_W = N_DEV - 1 + 2;

   if (N_GPIO > DATA_W) begin : g_bad_gpio
      $error("wake_agg_ctrl: N_GPIO must fit in DATA_W");
   end
   if (N_DEV > DATA_W) begin : g_bad_dev
      $error("wake_agg_ctrl: N_DEV must fit in DATA_W");
   end
   if ((1 << ADDR_W) <= ADDR_CTRL) begin : g_bad_addr
      $error("wake_agg_ctrl: ADDR_W too small for the register map");
   end

   logic any_rst_n;
   assign any_rst_n = sb_rst_n & main_rst_n;

   // bus decode: writes ignored while main reset is active
   logic wr_ok;
   assign wr_ok = bus_wr & main_rst_n;

   logic sel_gpio_en, sel_dev_en, sel_gpio_sts, sel_ctrl;
   assign sel_gpio_en  = (bus_addr == ADDR_W'(ADDR_GPIO_EN));
   assign sel_dev_en   = (bus_addr == ADDR_W'(ADDR_DEV_EN));
   assign sel_gpio_sts = (bus_addr == ADDR_W'(ADDR_GPIO_STS));
   assign sel_ctrl     = (bus_addr == ADDR_W'(ADDR_CTRL));

   // standby-domain enable registers
   logic [N_GPIO-1:0] gpio_en_q;
   logic [N_DEV-1:0]  dev_en_q;

   always_ff @(posedge clk or negedge sb_rst_n) begin
      if (!sb_rst_n) begin
         gpio_en_q <= '0;
         dev_en_q  <= '0;
      end else begin
         if (wr_ok && sel_gpio_en) gpio_en_q <= bus_wdata[N_GPIO-1:0];
         if (wr_ok && sel_dev_en)  dev_en_q  <= bus_wdata[N_DEV-1:0];
      end
   end

   // general-purpose wake path, standby domain
   logic [N_GPIO-1:0] gpio_s;
   logic [N_GPIO-1:0] gpio_clr;
   logic [N_GPIO-1:0] gpio_sts;

   wake_sync_bank #(.WIDTH(N_GPIO), .STAGES(SYNC_STAGES)) u_gpio_sync (
      .clk     (clk),
      .rst_n   (sb_rst_n),
      .d_async (gpio_wake_in),
      .q_sync  (gpio_s)
   );

   assign gpio_clr = (wr_ok && sel_gpio_sts) ? bus_wdata[N_GPIO-1:0] : '0;

   wake_edge_latch #(.N(N_GPIO)) u_gpio_latch (
      .clk   (clk),
      .rst_n (sb_rst_n),
      .lvl   (gpio_s),
      .clr   (gpio_clr),
      .sts   (gpio_sts)
   );

   // device path, cleared by either reset
   logic [DEV_SYNC_W-1:0] dev_raw, dev_sync;
   logic [N_DEV-1:0]      dev_vec;
   logic [DATA_W-1:0]     int_sts;

   assign dev_raw = {par_ack_in, par_active, dev_irq_in};

   wake_sync_bank #(.WIDTH(DEV_SYNC_W), .STAGES(SYNC_STAGES)) u_dev_sync (
      .clk     (clk),
      .rst_n   (any_rst_n),
      .d_async (dev_raw),
      .q_sync  (dev_sync)
   );

   wake_irq_view #(.N_DEV(N_DEV), .DATA_W(DATA_W)) u_irq_view (
      .clk       (clk),
      .rst_n     (any_rst_n),
      .dev_s     (dev_sync[N_DEV-2:0]),
      .par_act_s (dev_sync[N_DEV-1]),
      .par_ack_s (dev_sync[N_DEV]),
      .dev_vec   (dev_vec),
      .int_sts   (int_sts)
   );

   // main-domain control and outputs
   logic             gen_q;
   logic             wake_req_n_q;
   logic [N_DEV-1:0] wake_bus_q;

   always_ff @(posedge clk or negedge any_rst_n) begin
      if (!any_rst_n) begin
         gen_q        <= 1'b0;
         wake_req_n_q <= 1'b1;
         wake_bus_q   <= '0;
      end else begin
         if (wr_ok && sel_ctrl) gen_q <= bus_wdata[CTRL_GEN_BIT];
         wake_req_n_q <= ~(gen_q & (|(gpio_en_q & gpio_sts)));
         wake_bus_q   <= dev_en_q & dev_vec;
      end
   end

   assign wake_req_n = wake_req_n_q;
   assign wake_bus   = wake_bus_q;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(ADDR_GPIO_EN):  bus_rdata = DATA_W'(gpio_en_q);
         ADDR_W'(ADDR_DEV_EN):   bus_rdata = DATA_W'(dev_en_q);
         ADDR_W'(ADDR_INT_STS):  bus_rdata = int_sts;
         ADDR_W'(ADDR_GPIO_STS): bus_rdata = DATA_W'(gpio_sts);
         ADDR_W'(ADDR_CTRL):     bus_rdata = DATA_W'(gen_q);
         default:                bus_rdata = '0;
      endcase
   end

   // R2
   req_needs_gen_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
      !wake_req_n |-> $past(gen_q));

   // R6
   bus_needs_enable_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
      (wake_bus & ~$past(dev_en_q)) == '0);

   // R5
   enable_hold_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
      !main_rst_n |=> ($stable(gpio_en_q) && $stable(dev_en_q)));
endmodule

// File: tb/wake_agg_ctrl_tb_top.sv
module wake_agg_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       sb_rst_n = 1'b0;
   logic       main_rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] gpio_wake_in = '0;
   logic [6:0] dev_irq_in = '0;
   logic       par_active = 1'b0;
   logic       par_ack_in = 1'b0;
   logic       wake_req_n;
   logic [7:0] wake_bus;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [7:0] m_gen_en, m_dev_en, m_sts;
   logic       m_gen;

   always #2.5 clk = ~clk;

   wake_agg_ctrl dut_i (
      .clk(clk), .sb_rst_n(sb_rst_n), .main_rst_n(main_rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .gpio_wake_in(gpio_wake_in),
      .dev_irq_in(dev_irq_in), .par_active(par_active),
      .par_ack_in(par_ack_in), .wake_req_n(wake_req_n), .wake_bus(wake_bus)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic exp_par(input logic act, input logic ack);
      return act ? ack : 1'b1;
   endfunction

   function automatic logic [7:0] exp_int(input logic act, input logic ack, input logic [6:0] d);
      return {d[5], 2'b00, d[2], d[1], d[0], exp_par(act, ack), 1'b0};
   endfunction

   function automatic logic [7:0] exp_bus(input logic [7:0] en, input logic act,
                                          input logic ack, input logic [6:0] d);
      return en & {d, exp_par(act, ack)};
   endfunction

   function automatic logic exp_req_n(input logic g, input logic [7:0] en, input logic [7:0] s);
      return ~(g & (|(en & s)));
   endfunction

   task automatic set_gpio(input logic [7:0] v);
      @(negedge clk);
      m_sts = m_sts | (v & ~gpio_wake_in);
      gpio_wake_in = v;
      cyc(5);
   endtask

   initial begin
      int unsigned cnt = 0;
      while (!done) begin
         @(posedge clk);
         cnt++;
         if (cnt > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cnt);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] r;
      int unsigned seed;
      seed = $urandom(32'h0000_5eed);
      m_gen_en = '0; m_dev_en = '0; m_sts = '0; m_gen = 1'b0;
      cyc(3);
      sb_rst_n = 1'b1; main_rst_n = 1'b1;
      cyc(3);

      // R1 reset state
      rd(3'd0, r); check("R1 gpio_en reset", r, 8'h00);
      rd(3'd1, r); check("R1 dev_en reset", r, 8'h00);
      rd(3'd2, r); check("R1 int_sts reset", r, 8'h02);
      rd(3'd3, r); check("R1 gpio_sts reset", r, 8'h00);
      rd(3'd4, r); check("R1 ctrl reset", r, 8'h00);
      rd(3'd6, r); check("R1 unused addr", r, 8'h00);
      check("R1 wake_req_n reset", wake_req_n, 1'b1);
      check("R1 wake_bus reset", wake_bus, 8'h00);

      // R3 disabled source records status, no request
      wr(3'd4, 8'h01); m_gen = 1'b1;
      set_gpio(8'h04);
      rd(3'd3, r); check("R3 status recorded while disabled", r, 8'h04);
      check("R3 disabled source no request", wake_req_n, 1'b1);

      // R3 latency: readable three edges after change
      @(negedge clk); gpio_wake_in = 8'h14; m_sts = m_sts | 8'h10;
      cyc(2); rd(3'd3, r); check("R3 not yet latched after 2 edges", r, 8'h04);
      cyc(1); rd(3'd3, r); check("R3 latched after 3 edges", r, 8'h14);

      // R2 request asserts once enabled
      wr(3'd0, 8'h10); m_gen_en = 8'h10;
      cyc(1);
      check("R2 request asserted", wake_req_n, 1'b0);
      wr(3'd4, 8'h00); m_gen = 1'b0;
      cyc(1);
      check("R2 held high with global enable off", wake_req_n, 1'b1);
      wr(3'd4, 8'h01); m_gen = 1'b1;
      cyc(1);

      // R4 write-1-to-clear selectivity
      wr(3'd3, 8'h00); rd(3'd3, r); check("R4 write 0 keeps bits", r, 8'h14);
      wr(3'd3, 8'h10); m_sts = m_sts & ~8'h10;
      rd(3'd3, r); check("R4 clear written bit only", r, 8'h04);
      cyc(1);
      check("R4 request drops after clear", wake_req_n, 1'b1);

      // R6 / R7 / R8 / R9 device directed
      @(negedge clk); dev_irq_in = 7'h27; par_active = 1'b0; par_ack_in = 1'b0;
      cyc(4);
      rd(3'd2, r); check("R7 int_sts layout", r, exp_int(1'b0, 1'b0, 7'h27));
      check("R6 bus gated by zero enable", wake_bus, 8'h00);
      wr(3'd2, 8'h00); rd(3'd2, r); check("R9 write to int_sts ignored", r, exp_int(1'b0, 1'b0, 7'h27));
      @(negedge clk); par_active = 1'b1; cyc(4);
      rd(3'd2, r); check("R8 parallel follows ack low", r[1], 1'b0);
      @(negedge clk); par_ack_in = 1'b1; cyc(4);
      rd(3'd2, r); check("R8 parallel follows ack high", r[1], 1'b1);
      @(negedge clk); dev_irq_in = 7'h00; cyc(4);
      rd(3'd2, r); check("R9 clears when source deasserts", r, 8'h02);
      wr(3'd1, 8'hff); m_dev_en = 8'hff; cyc(2);
      check("R6 bus enabled", wake_bus, exp_bus(8'hff, 1'b1, 1'b1, 7'h00));

      // R5 / R10 main reset
      wr(3'd0, 8'h5a); m_gen_en = 8'h5a;
      wr(3'd1, 8'hc3); m_dev_en = 8'hc3;
      @(negedge clk); main_rst_n = 1'b0;
      bus_addr = 3'd0; bus_wdata = 8'hff; bus_wr = 1'b1;
      cyc(2); bus_wr = 1'b0; main_rst_n = 1'b1; m_gen = 1'b0;
      @(negedge clk); par_active = 1'b0;
      cyc(1);
      rd(3'd0, r); check("R5 gpio_en survives main reset", r, 8'h5a);
      rd(3'd1, r); check("R5 dev_en survives main reset", r, 8'hc3);
      rd(3'd3, r); check("R5 status survives main reset", r, m_sts);
      rd(3'd4, r); check("R10 ctrl cleared by main reset", r, 8'h00);
      rd(3'd2, r); check("R10 int_sts after main reset", r, 8'h02);

      // random phase
      for (int it = 0; it < 300; it++) begin
         int unsigned op = $urandom_range(0, 5);
         case (op)
            0: set_gpio(8'($urandom));
            1: begin logic [7:0] v = 8'($urandom); wr(3'd0, v); m_gen_en = v; end
            2: begin logic [7:0] v = 8'($urandom); wr(3'd3, v); m_sts = m_sts & ~v; end
            3: begin logic v = 1'($urandom); wr(3'd4, {7'b0, v}); m_gen = v; end
            4: begin logic [7:0] v = 8'($urandom); wr(3'd1, v); m_dev_en = v; end
            default: begin
               @(negedge clk);
               dev_irq_in = 7'($urandom); par_active = 1'($urandom); par_ack_in = 1'($urandom);
               cyc(4);
            end
         endcase
         cyc(2);
         rd(3'd3, r); check("R3 random status", r, m_sts);
         check("R2 random request", wake_req_n, exp_req_n(m_gen, m_gen_en, m_sts));
         check("R6 random bus", wake_bus, exp_bus(m_dev_en, par_active, par_ack_in, dev_irq_in));
         rd(3'd2, r); check("R7 random int_sts", r, exp_int(par_active, par_ack_in, dev_irq_in));
      end

      // R1 standby reset clears enables
      @(negedge clk); sb_rst_n = 1'b0; cyc(2); sb_rst_n = 1'b1; cyc(1);
      rd(3'd0, r); check("R1 gpio_en after standby reset", r, 8'h00);
      rd(3'd1, r); check("R1 dev_en after standby reset", r, 8'h00);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule